// File: doc/BRIEF.md
# Transmit Descriptor Polling Timer

This block sits inside an Ethernet MAC. It decides when the transmit engine should look at the current transmit buffer descriptor to see whether software has handed it to the MAC. The host writes an 8-bit period value. A free-running prescaler divides the system clock by 256, and the interval counter counts prescaler ticks up to the period, so checks are spaced 256 × period clock cycles apart. Each write of a nonzero period forces a check at once and restarts both counters. A check is a one-cycle strobe on `chk_o`.

A check that finds the descriptor owned by the MAC raises a start-transmit request. The request stays high until the engine acknowledges it. A check that finds the descriptor owned by the host changes nothing.

A period of zero turns polling off. It also blocks the start of new frames. A frame already in flight is allowed to finish, because the transmit-enable qualifier stays high while the engine reports busy. A check that falls due while the engine is busy waits for the first idle cycle and is never lost.

Top module: `tx_poll_timer`

## Requirements
- R1: After reset the period is zero, and `chk_o`, `tx_req_o` and `tx_en_o` are all low.
- R2: A write of a nonzero period (`wr_en_i` high for one cycle with `wr_data_i` != 0) makes `chk_o` high for exactly one cycle: the cycle right after the write, provided `tx_busy_i` is low.
- R3: With a nonzero period P held, successive `chk_o` strobes start exactly 256 × P clock cycles apart.
- R4: A write during an interval restarts the prescaler and the interval counter. The strobe caused by the write is followed by the next strobe 256 × P_new cycles later.
- R5: While the period is zero, `chk_o` stays low and `tx_req_o` stays low. A write of zero causes no check and cancels any check still waiting.
- R6: A check that falls due while `tx_busy_i` is high is held back. It appears on `chk_o` in the first cycle in which `tx_busy_i` is low.
- R7: A strobe seen with `desc_own_i` = 1 (1 means the MAC owns the descriptor) sets `tx_req_o` from the next cycle on. The request holds until the cycle after `tx_ack_i` is high. A strobe with `desc_own_i` = 0 leaves `tx_req_o` low.
- R8: `tx_en_o` is high when the period is nonzero or `tx_busy_i` is high, so a frame in flight completes after the period drops to zero. Otherwise `tx_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe for the period register |
| wr_data_i | input | 8 | Period value written by the host |
| desc_own_i | input | 1 | Descriptor ownership bit, 1 = owned by the MAC |
| tx_busy_i | input | 1 | Transmit engine is sending a frame |
| tx_ack_i | input | 1 | Transmit engine accepts the start request |
| chk_o | output | 1 | One-cycle descriptor check strobe |
| tx_req_o | output | 1 | Start-transmit request |
| tx_en_o | output | 1 | Transmit-enable qualifier |

## Verification
The bench measures strobe spacing for periods 1, 2, 3, 7 and 16. An off-by-one in the prescaler or in the interval compare would show up as a gap of 255 or 257 cycles per tick. It rewrites the period mid-interval. A design that failed to clear the counters would fire the next strobe early.

The bench holds the engine busy across a due check. A design that drops the check instead of deferring it would never strobe. Finally, it drops the period to zero while a request is pending and while a frame is in flight. A wrong design would either issue the request or cut the frame's enable.

// File: rtl/tx_poll_pkg.sv
package tx_poll_pkg;
  localparam int unsigned PRESCALE_DIV_DEF = 256;
  localparam int unsigned PER_W_DEF        = 8;
endpackage

// File: rtl/tx_poll_prescaler.sv
module tx_poll_prescaler #(
  parameter int unsigned DIV = tx_poll_pkg::PRESCALE_DIV_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_count
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             cnt_q <= '0;
        else if (clr_i)          cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + CW'(1);
      end

      assign tick_o = (cnt_q == LAST);

      // R3: the divider wraps to zero after every tick
      assert_tick_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (cnt_q == '0));
      // R4: a clear restarts the divider
      assert_clr_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0));
    end
  endgenerate
endmodule

// File: rtl/tx_poll_interval.sv
module tx_poll_interval #(
  parameter int unsigned PER_W = tx_poll_pkg::PER_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] period_i,
  output logic             due_o
);
  logic [PER_W-1:0] ivl_q;
  logic             per_nz;

  assign per_nz = (period_i != '0);
  assign due_o  = tick_i && per_nz && (ivl_q == period_i - PER_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ivl_q <= '0;
    else if (clr_i)   ivl_q <= '0;
    else if (due_o)   ivl_q <= '0;
    else if (tick_i && per_nz) ivl_q <= ivl_q + PER_W'(1);
  end

  // R3: an interval only ends on a prescaler tick
  assert_due_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due_o |-> tick_i);
  // R5: no interval ends while the period is zero
  assert_no_due_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i == '0) |-> !due_o);
endmodule

// File: rtl/tx_poll_arbiter.sv
module tx_poll_arbiter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic per_nz_i,
  input  logic wr_go_i,
  input  logic wr_zero_i,
  input  logic due_i,
  input  logic busy_i,
  input  logic own_i,
  input  logic ack_i,
  output logic chk_o,
  output logic req_o
);
  logic pend_q, req_q;

  assign chk_o = pend_q && per_nz_i && !busy_i;
  assign req_o = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pend_q <= 1'b0;
    else if (wr_zero_i)         pend_q <= 1'b0;
    else if (wr_go_i || due_i)  pend_q <= 1'b1;
    else if (chk_o)             pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               req_q <= 1'b0;
    else if (chk_o && own_i)   req_q <= 1'b1;
    else if (ack_i)            req_q <= 1'b0;
  end

  // R6: a waiting check leaves only by being issued or cancelled by a zero write
  assert_no_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_q) |-> $past(chk_o || wr_zero_i));
  // R6: the strobe never coincides with a busy engine
  assert_defer_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !chk_o);
  // R7: a request only rises after a strobe that saw MAC ownership
  assert_req_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(chk_o && own_i));
  // R7: the request holds until acknowledged
  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !ack_i) |=> req_q);
endmodule

// File: rtl/tx_poll_timer.sv
module tx_poll_timer #(
  parameter int unsigned PRESCALE_DIV = tx_poll_pkg::PRESCALE_DIV_DEF,
  parameter int unsigned PER_W        = tx_poll_pkg::PER_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PER_W-1:0] wr_data_i,
  input  logic             desc_own_i,
  input  logic             tx_busy_i,
  input  logic             tx_ack_i,
  output logic             chk_o,
  output logic             tx_req_o,
  output logic             tx_en_o
);
  logic [PER_W-1:0] period_q;
  logic             per_nz, wr_go, wr_zero, tick, due, req_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      period_q <= '0;
    else if (wr_en_i) period_q <= wr_data_i;
  end

  assign per_nz  = (period_q != '0);
  assign wr_go   = wr_en_i && (wr_data_i != '0);
  assign wr_zero = wr_en_i && (wr_data_i == '0);

  tx_poll_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(wr_en_i), .tick_o(tick)
  );

  tx_poll_interval #(.PER_W(PER_W)) u_ivl (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(wr_en_i), .tick_i(tick),
    .period_i(period_q), .due_o(due)
  );

  tx_poll_arbiter u_arb (
    .clk_i   (clk_i),   .rst_ni   (rst_ni),
    .per_nz_i(per_nz),  .wr_go_i  (wr_go),   .wr_zero_i(wr_zero),
    .due_i   (due),     .busy_i   (tx_busy_i),
    .own_i   (desc_own_i), .ack_i (tx_ack_i),
    .chk_o   (chk_o),   .req_o    (req_raw)
  );

  // New frames only start while polling is on; an active frame keeps its enable.
  assign tx_req_o = req_raw && per_nz;
  assign tx_en_o  = per_nz || tx_busy_i;

  // R2: a nonzero write is followed by a strobe when the engine is idle
  assert_wr_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go ##1 !tx_busy_i |-> chk_o);
  // R5: no start request while polling is off
  assert_no_req_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_nz |-> !tx_req_o);
  // R8: an in-flight frame never loses its enable
  assert_busy_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |-> tx_en_o);
endmodule

// File: tb/tx_poll_timer_tb.sv
module tx_poll_timer_tb;
  localparam int unsigned NV = 5;
  localparam int unsigned VEC_PER [NV] = '{1, 2, 3, 7, 16};
  localparam int unsigned DIV = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       own = 1'b0, busy = 1'b0, ack = 1'b0;
  logic       chk, req, en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  tx_poll_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .desc_own_i(own), .tx_busy_i(busy), .tx_ack_i(ack),
    .chk_o(chk), .tx_req_o(req), .tx_en_o(en)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // write on one cycle; returns sampled just after the following negedge
  task automatic wr_period(input int p);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'(p);
    @(negedge clk); wr_en = 1'b0; #1;
  endtask

  task automatic step;
    @(negedge clk); #1;
  endtask

  // cycles until chk goes high, capped
  task automatic gap_to_chk(output int n);
    n = 0;
    do begin step(); n++; end while (!chk && n < 70000);
  endtask

  initial begin
    int g;
    int seen;
    repeat (3) @(negedge clk);
    #1;
    check(chk == 1'b0 && req == 1'b0 && en == 1'b0, "R1 reset outputs", {chk, req, en}, 0);
    rst_n = 1'b1;
    repeat (300) step();
    check(chk == 1'b0, "R1 idle after reset (period 0)", chk, 0);

    // period table: immediate strobe, width, two gaps
    for (int i = 0; i < NV; i++) begin
      wr_period(int'(VEC_PER[i]));
      check(chk == 1'b1, "R2 strobe after write", chk, 1);
      step();
      check(chk == 1'b0, "R2 strobe one cycle wide", chk, 0);
      gap_to_chk(g);
      check(g == int'(DIV * VEC_PER[i]) - 1, "R3 first interval", g + 1, int'(DIV * VEC_PER[i]));
      gap_to_chk(g);
      check(g == int'(DIV * VEC_PER[i]), "R3 second interval", g, int'(DIV * VEC_PER[i]));
      check(req == 1'b0, "R7 host-owned descriptor no request", req, 0);
    end

    // R4: rewrite mid-interval restarts the counters
    wr_period(4);
    repeat (300) step();
    wr_period(2);
    check(chk == 1'b1, "R4 strobe on rewrite", chk, 1);
    gap_to_chk(g);
    check(g == 512, "R4 interval after rewrite", g, 512);

    // R6: check due while busy is deferred, not dropped
    busy = 1'b1;
    wr_period(1);
    check(chk == 1'b0, "R6 no strobe while busy", chk, 0);
    check(en == 1'b1, "R8 enable while period nonzero", en, 1);
    repeat (20) step();
    check(chk == 1'b0, "R6 still held while busy", chk, 0);
    @(negedge clk); busy = 1'b0; #1;
    check(chk == 1'b1, "R6 deferred strobe on first idle cycle", chk, 1);
    step();
    check(chk == 1'b0, "R6 deferred strobe one cycle", chk, 0);

    // R7: MAC-owned descriptor raises request held until ack
    own = 1'b1;
    wr_period(8);
    check(chk == 1'b1 && req == 1'b0, "R7 strobe before request", {chk, req}, 2);
    step();
    check(req == 1'b1, "R7 request after owned check", req, 1);
    repeat (10) step();
    check(req == 1'b1, "R7 request held without ack", req, 1);
    @(negedge clk); ack = 1'b1; #1;
    check(req == 1'b1, "R7 request during ack cycle", req, 1);
    @(negedge clk); ack = 1'b0; own = 1'b0; #1;
    check(req == 1'b0, "R7 request cleared after ack", req, 0);

    // R5: zero period gates a pending request and stops strobes
    own = 1'b1;
    wr_period(3);
    step();
    own = 1'b0;
    check(req == 1'b1, "R7 request raised", req, 1);
    wr_period(0);
    check(req == 1'b0, "R5 request gated at period zero", req, 0);
    check(en == 1'b0, "R8 enable low at period zero idle", en, 0);
    seen = 0;
    for (int k = 0; k < 1000; k++) begin step(); if (chk) seen++; end
    check(seen == 0, "R5 no strobes at period zero", seen, 0);

    // R8: frame in flight keeps enable after period drops to zero
    wr_period(5);
    @(negedge clk); busy = 1'b1; #1;
    wr_period(0);
    check(en == 1'b1, "R8 in-flight frame keeps enable", en, 1);
    repeat (50) step();
    check(en == 1'b1, "R8 enable held while busy", en, 1);
    @(negedge clk); busy = 1'b0; #1;
    check(en == 1'b0, "R8 enable drops when frame done", en, 0);

    // R5: a zero write cancels a check deferred by busy
    @(negedge clk); busy = 1'b1; #1;
    wr_period(2);
    wr_period(0);
    @(negedge clk); busy = 1'b0; #1;
    seen = 0;
    for (int k = 0; k < 600; k++) begin step(); if (chk) seen++; end
    check(seen == 0, "R5 zero write cancels waiting check", seen, 0);

    // R1: reset mid-operation
    wr_period(1);
    @(negedge clk); rst_n = 1'b0; #1;
    check(chk == 1'b0 && req == 1'b0 && en == 1'b0, "R1 async reset clears outputs", {chk, req, en}, 0);
    @(negedge clk); rst_n = 1'b1;
    seen = 0;
    for (int k = 0; k < 600; k++) begin step(); if (chk) seen++; end
    check(seen == 0, "R1 period zero after reset", seen, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule